// File: doc/BRIEF.md
# Flit Packet Routing Node

This block steers packets on a 16-bit flit bus from one input link to one of eight output links. Every link carries a flit word, a valid strobe, a ready strobe going back to the sender, and a continuation wire. The sender raises the continuation wire on every flit of a packet except the last one. A flit moves only in a cycle where valid and ready are both high.

The node decodes the destination from the first flit of each packet. The top bit of that flit picks the class: memory bank or compute element. For compute traffic, the position of the element number depends on the two-bit prefix. The node then holds that route for every following flit and does not inspect them. When a flit with the continuation wire low has moved, the route is released, and the next flit is decoded as the start of a new packet.

The path is combinational from input to output, so each flit moves in the cycle it is offered. The route register only keeps the decision across the rest of a packet. Backpressure from the chosen output is passed straight back to the sender.

Top module: `flit_router`

## Requirements
- R1: The output port index is 0 to 3 for compute elements (port = element number) and 4 to 7 for memory banks (port = 4 + bank number). Bit 15 of the first flit selects memory (1) or compute (0).
- R2: For a memory packet (bit 15 = 1), the bank number is bits [14:13] of the first flit.
- R3: For a compute packet whose bits [15:14] are 00, the element number is bits [13:12] of the first flit.
- R4: For a compute packet whose bits [15:14] are 01, the element number is bits [12:11] of the first flit, whatever bit 13 holds.
- R5: Every flit after the first goes to the port chosen by the first flit, whatever its own bits contain.
- R6: The flit that moves with the continuation wire low closes the packet, and the next flit offered is decoded as a new first flit.
- R7: A packet of one flit (continuation low on the first flit) is routed and closed in that single transfer, and the next packet is decoded afresh.
- R8: At most one output valid is high at any time, and only while the input valid is high. Input ready equals the ready of the selected output: the held route during a packet, or the decode of the offered flit between packets.
- R9: While the selected output holds ready low, the route is held, the offered flit is not consumed, and no other output sees it.
- R10: After reset the node has no active route, and the first flit offered is decoded as a packet start, even if reset cut a packet short.
- R11: The flit word and the continuation wire arrive unchanged on the selected output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 16 | Incoming flit word |
| in_valid | input | 1 | Incoming flit present |
| in_more | input | 1 | More flits follow in this packet |
| in_ready | output | 1 | Node can take the offered flit |
| out_data | output | 8x16 | Flit word per output port |
| out_valid | output | 8 | Flit present, per output port |
| out_more | output | 8 | Continuation wire, per output port |
| out_ready | input | 8 | Per-port receiver can accept |

## Verification
The route decode and the packet close can fall in the same transfer, when a one-flit packet arrives. A packet close can also be followed at once by the decode of the next packet in the very next cycle. The bench sends runs of one-flit packets to alternating ports back to back, and follows multi-flit packets immediately with packets to other ports, both with and without random backpressure. The scoreboard judges each transfer by the port it appears on and the word and continuation bit it carries. It also checks in every offered cycle that input ready follows the ready of the expected port.

// File: rtl/flit_router_pkg.sv
package flit_router_pkg;
  localparam int FLIT_W    = 16;
  localparam int ID_W      = 2;
  localparam int NUM_CE    = 1 << ID_W;
  localparam int NUM_MB    = 1 << ID_W;
  localparam int NUM_PORTS = NUM_CE + NUM_MB;
  localparam int PORT_W    = $clog2(NUM_PORTS);
  localparam int CLASS_BIT = FLIT_W - 1;

  typedef logic [PORT_W-1:0] port_t;

  typedef struct packed {
    logic            is_mem;
    logic [ID_W-1:0] id;
  } dest_t;

  // Destination field sits at a prefix-dependent position.
  function automatic dest_t pick_dest(input logic [FLIT_W-1:0] f);
    dest_t d;
    d.is_mem = f[CLASS_BIT];
    if (f[CLASS_BIT])
      d.id = f[CLASS_BIT-1 -: ID_W];
    else if (!f[CLASS_BIT-1])
      d.id = f[CLASS_BIT-2 -: ID_W];
    else
      d.id = f[CLASS_BIT-3 -: ID_W];
    return d;
  endfunction

  // Compute elements occupy the low ports, memory banks the high ones.
  function automatic port_t dest_to_port(input dest_t d);
    port_t base;
    base = d.is_mem ? port_t'(NUM_CE) : '0;
    return base + port_t'(d.id);
  endfunction
endpackage

// File: rtl/flit_route_decode.sv
module flit_route_decode
  import flit_router_pkg::*;
(
  input  logic [FLIT_W-1:0] flit,
  output port_t             dec_port
);
  dest_t dest;
  always_comb begin
    dest     = pick_dest(flit);
    dec_port = dest_to_port(dest);
  end
endmodule

// File: rtl/flit_route_track.sv
module flit_route_track
  import flit_router_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  xfer,
  input  logic  flit_more,
  input  port_t dec_port,
  output logic  active,
  output port_t cur_port
);
  port_t route_port;
  logic  pkt_open;
  logic  pkt_close;

  assign pkt_open  = xfer && !active && flit_more;
  assign pkt_close = xfer && !flit_more;
  assign cur_port  = active ? route_port : dec_port;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      route_port <= '0;
    end else if (pkt_open) begin
      active     <= 1'b1;
      route_port <= dec_port;
    end else if (pkt_close) begin
      active     <= 1'b0;
    end
  end

  // R6
  pkt_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !flit_more |=> !active);

  // R5
  route_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active && xfer && flit_more |=> active && route_port == $past(dec_port));

  // R9
  route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && !(xfer && !flit_more) |=> active && $stable(route_port));
endmodule

// File: rtl/flit_out_demux.sv
module flit_out_demux
  import flit_router_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  port_t                              cur_port,
  input  logic [FLIT_W-1:0]                  in_data,
  input  logic                               in_valid,
  input  logic                               in_more,
  input  logic [NUM_PORTS-1:0]               out_ready,
  output logic [NUM_PORTS-1:0][FLIT_W-1:0]   out_data,
  output logic [NUM_PORTS-1:0]               out_valid,
  output logic [NUM_PORTS-1:0]               out_more,
  output logic                               in_ready
);
  logic [NUM_PORTS-1:0] sel_hot;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign sel_hot[p]   = (cur_port == port_t'(p));
    assign out_data[p]  = in_data;
    assign out_valid[p] = in_valid && sel_hot[p];
    assign out_more[p]  = in_more && sel_hot[p];
  end

  assign in_ready = |(sel_hot & out_ready);

  // R8
  one_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid) && (in_valid || out_valid == '0));

  // R8
  ready_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_ready == |(out_valid & out_ready));
endmodule

// File: rtl/flit_router.sv
module flit_router
  import flit_router_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [FLIT_W-1:0]                in_data,
  input  logic                             in_valid,
  input  logic                             in_more,
  output logic                             in_ready,
  output logic [NUM_PORTS-1:0][FLIT_W-1:0] out_data,
  output logic [NUM_PORTS-1:0]             out_valid,
  output logic [NUM_PORTS-1:0]             out_more,
  input  logic [NUM_PORTS-1:0]             out_ready
);
  port_t dec_port;
  port_t cur_port;
  logic  active;
  logic  xfer;

  assign xfer = in_valid && in_ready;

  flit_route_decode u_decode (
    .flit     (in_data),
    .dec_port (dec_port)
  );

  flit_route_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer      (xfer),
    .flit_more (in_more),
    .dec_port  (dec_port),
    .active    (active),
    .cur_port  (cur_port)
  );

  flit_out_demux u_demux (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_port  (cur_port),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_more   (in_more),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_more  (out_more),
    .in_ready  (in_ready)
  );

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !active);
endmodule

// File: tb/flit_router_tb.sv
module flit_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int WATCHDOG = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_more = 1'b0;
  logic in_ready;
  logic [NP-1:0][15:0] out_data;
  logic [NP-1:0] out_valid;
  logic [NP-1:0] out_more;
  logic [NP-1:0] out_ready = '1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit bp_en = 1'b0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  typedef struct {
    int          port;
    logic [15:0] data;
    logic        more;
    string       req;
  } exp_t;
  exp_t sb[$];

  flit_router u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_more(in_more), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_more(out_more), .out_ready(out_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected port from the requirement text (R1..R4), int arithmetic.
  function automatic int ref_port(input logic [15:0] f);
    int v;
    v = int'(f);
    if (v >= 32768) return 4 + ((v >> 13) & 3);
    if (((v >> 14) & 1) == 0) return (v >> 12) & 3;
    return (v >> 11) & 3;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  // Random backpressure, changed just after each edge.
  always begin
    @(posedge clk);
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_en ? lfsr[7:0] : '1;
  end

  // Scoreboard monitor, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (in_valid && sb.size() > 0) begin
        // R8: ready follows the expected port; no other port sees the flit
        chk(in_ready == out_ready[sb[0].port], "R8", "in_ready",
            int'(in_ready), int'(out_ready[sb[0].port]));
        chk(out_valid == (NP'(1) << sb[0].port), sb[0].req, "out_valid",
            int'(out_valid), int'(NP'(1) << sb[0].port));
      end else if (!in_valid) begin
        chk(out_valid == '0, "R8", "idle out_valid", int'(out_valid), 0);
      end
      for (int p = 0; p < NP; p++) begin
        if (out_valid[p] && out_ready[p]) begin
          if (sb.size() == 0) begin
            chk(1'b0, "R8", "unexpected transfer port", p, -1);
          end else begin
            exp_t e;
            e = sb.pop_front();
            chk(p == e.port, e.req, "port", p, e.port);
            // R11: word and continuation unchanged
            chk(out_data[p] == e.data, "R11", "data", int'(out_data[p]), int'(e.data));
            chk(out_more[p] == e.more, "R11", "more", int'(out_more[p]), int'(e.more));
          end
        end
      end
    end
  end

  task automatic push_flit(input logic [15:0] d, input logic m);
    in_valid = 1'b1;
    in_data  = d;
    in_more  = m;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic send_pkt(input logic [15:0] f0, input logic [15:0] f1,
                          input logic [15:0] f2, input logic [15:0] f3,
                          input int n, input string req);
    logic [15:0] fl [4];
    int port;
    fl[0] = f0; fl[1] = f1; fl[2] = f2; fl[3] = f3;
    port = ref_port(f0);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.port = port;
      e.data = fl[i];
      e.more = (i != n - 1);
      e.req  = (i == 0) ? req : "R5";
      sb.push_back(e);
    end
    for (int i = 0; i < n; i++) push_flit(fl[i], i != n - 1);
    in_valid = 1'b0;
    in_more  = 1'b0;
  endtask

  task automatic drain();
    int w;
    w = 0;
    while (sb.size() > 0 && w < 1000) begin
      @(negedge clk);
      w++;
    end
    chk(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 0);
  endtask

  initial begin
    in_data = 16'h8000;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    // R10: reset state, nothing forwarded
    chk(out_valid == '0, "R10", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    @(negedge clk);
    chk(out_valid == '0, "R10", "out_valid after reset", int'(out_valid), 0);
    @(posedge clk);
    #1;

    // R1/R2: every memory bank
    for (int b = 0; b < 4; b++)
      send_pkt(16'h8000 | 16'(b << 13) | 16'h0155, 16'h1234 + 16'(b), 0, 0, 2, "R2");
    // R3: prefix 00 elements
    for (int c = 0; c < 4; c++)
      send_pkt(16'h0000 | 16'(c << 12) | 16'h00A7, 16'hBEEF, 0, 0, 2, "R3");
    // R4: prefix 01 elements, bit 13 both ways
    for (int c = 0; c < 4; c++) begin
      send_pkt(16'h4000 | 16'(c << 11) | 16'h0033, 16'h0F0F, 0, 0, 2, "R4");
      send_pkt(16'h6000 | 16'(c << 11) | 16'h0100, 16'h7777, 0, 0, 2, "R4");
    end
    drain();

    // R5: later flits that look like other destinations stay on element 2
    send_pkt(16'h2000, 16'hFFFF, 16'h8000, 16'h5800, 4, "R5");
    // R6: next packet right after, different port
    send_pkt(16'hA000, 16'h0000, 16'h3000, 0, 3, "R6");
    // R7: one-flit packets back to back to alternating ports
    for (int k = 0; k < 8; k++)
      send_pkt(k[0] ? 16'hE000 : 16'h0800 | 16'(k), 0, 0, 0, 1, "R7");
    drain();

    // R9: random backpressure on mixed traffic
    bp_en = 1'b1;
    for (int k = 0; k < 40; k++) begin
      logic [15:0] h;
      h = 16'(k * 16'h1A37 + 16'h0B11);
      send_pkt(h, ~h, h ^ 16'h8000, 16'h6000, (k % 4) + 1, "R9");
    end
    drain();
    bp_en = 1'b0;
    @(posedge clk);
    #1;

    // R10: reset in the middle of a packet, then fresh decode
    sb.push_back('{port: 1, data: 16'h1000, more: 1'b1, req: "R10"});
    push_flit(16'h1000, 1'b1);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    send_pkt(16'hC000, 0, 0, 0, 1, "R10");
    drain();

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule